// File: doc/BRIEF.md
# Codec Serial Port Register Controller

This block is the slave end of a four-wire serial link between a host and a codec. The host drives a shift clock, a frame strobe and a data line into the block; the block drives one data line back. Frames alternate between two kinds. A *primary* frame carries a 16-bit converter sample to the host while the host sends a 16-bit playback word, which the block presents on a parallel output with a one-cycle valid strobe.

A primary frame may ask for a *secondary* frame to follow it. The request comes either in-band, from bit 0 of the playback word, or from a dedicated request pin held high during the primary frame. In the secondary frame the host sends a 16-bit control word that either writes or reads back one 8-bit register in a small bank with reset defaults. During that frame the block echoes the command byte back on its output while the command byte arrives. It then sends the addressed register's contents, or zero, as the low byte.

All serial lines are sampled into the block's own clock domain through a synchronizer. The shift clock must therefore be slow enough that each half period spans several system clocks.

Top module: `codec_sp_ctrl`

## Requirements
- R1: After synchronous reset `rst`, `dac_word` is 0, `dac_valid` is low, every register holds its default, and the next frame is handled as a primary frame.
- R2: In a primary frame the block shifts `adc_word` (captured at the start of the frame) out on `dout` most significant bit first. Each bit is valid at the falling edge of `sclk` at which the host samples it.
- R3: Input bits are sampled on falling `sclk` edges while `fs` is high, MSB first. At the end of a primary frame, `dac_word` takes the received word with bit 0 cleared, and `dac_valid` pulses for one clock. `dac_word` changes at no other time.
- R4: A primary word with bit 0 = 1 makes the next frame a secondary frame.
- R5: `hw_req` high at any sampled bit of a primary frame makes the next frame a secondary frame, even when bit 0 of the word is 0.
- R6: A primary frame with no request is followed by another primary frame, and a secondary frame is always followed by a primary frame.
- R7: A secondary word writes its low byte (bits 7..0) into the register whose address is in bits 12..8 when bit 13 (read flag) is 0, bits 15..14 are 0, and the address is in 1..NUM_REGS. The update happens at the end of the frame and only there.
- R8: In a secondary frame, `dout` repeats bits 15..8 of the incoming word in the same bit positions. When bit 13 is 1, the low byte of `dout` carries the addressed register, and the register is not written.
- R9: A secondary word whose bits 15..8 are all zero changes nothing. A word with a nonzero bit 15 or 14, or with an address above NUM_REGS, writes nothing, and a read with such an address returns a zero low byte.
- R10: A register never written keeps its default value: address 1 = 8'h81, 2 = 8'h00, 3 = 8'hA5, 4 = 8'h3F, 5 = 8'h00, 6 = 8'h0C. `ctrl_regs` carries address k in bits [(k-1)*8 +: 8].
- R11: A frame in which `fs` falls before 16 bits arrive is discarded: no strobe, no write, no frame-kind change. The next frame starts from bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial shift clock from host |
| fs | input | 1 | Frame strobe, high for the 16 bits of a frame |
| din | input | 1 | Serial data from host (playback word or control word) |
| hw_req | input | 1 | Pin request for a secondary frame |
| dout | output | 1 | Serial data to host (sample or readback) |
| adc_word | input | 16 | Converter sample sent in primary frames |
| dac_word | output | 16 | Last received playback word |
| dac_valid | output | 1 | One-cycle strobe when `dac_word` updates |
| ctrl_regs | output | NUM_REGS*8 | Register bank contents, address 1 in the low byte |

## Verification
The assertions watch cycle-level invariants on every clock: the playback strobe lasts one cycle, `dac_word` moves only with it and never in a secondary frame, registers change only after a write decoded in a secondary frame, and defaults appear right after reset. The bit-level serial behaviour is left to the bench scenarios. This covers MSB-first ordering, the command-byte echo, readback content, the choice between software and pin requests, rejected writes to out-of-range and reserved addresses, and recovery from a truncated frame.

// File: rtl/codec_sp_pkg.sv
package codec_sp_pkg;

   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 5;
   localparam int CNT_W  = 5;

   typedef enum logic {
      FR_PRI = 1'b0,
      FR_SEC = 1'b1
   } frame_e;

   typedef struct packed {
      logic [1:0]        rsv;
      logic              rd;
      logic [ADDR_W-1:0] addr;
   } cmd_t;

   function automatic logic cmd_hits(input cmd_t c, input int nregs);
      return (c.rsv == 2'b00) && (c.addr != '0) && (int'(c.addr) <= nregs);
   endfunction

endpackage

// File: rtl/codec_sp_sync.sv
module codec_sp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sclk,
   input  logic fs,
   input  logic din,
   input  logic hw_req,
   output logic sclk_fall,
   output logic fs_q,
   output logic fs_rise,
   output logic din_q,
   output logic hw_q
);
   localparam int LANES = 4;

   logic [LANES-1:0] pipe [STAGES];
   logic [LANES-1:0] last;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("codec_sp_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
         last <= '0;
      end else begin
         pipe[0] <= {hw_req, din, fs, sclk};
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         last <= pipe[STAGES-1];
      end
   end

   assign sclk_fall = last[0] & ~pipe[STAGES-1][0];
   assign fs_q      = pipe[STAGES-1][1];
   assign fs_rise   = ~last[1] & pipe[STAGES-1][1];
   assign din_q     = pipe[STAGES-1][2];
   assign hw_q      = pipe[STAGES-1][3];

endmodule

// File: rtl/codec_sp_shift.sv
module codec_sp_shift
   import codec_sp_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              fs_q,
   input  logic              fs_rise,
   input  logic              bit_stb,
   input  logic              din_q,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              hi_load,
   input  logic [BYTE_W-1:0] hi_val,
   output logic              tx_bit,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic              half_done,
   output logic [BYTE_W-1:0] upper_byte,
   output logic              word_done,
   output logic [WORD_W-1:0] rx_word
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] MID_BIT  = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(WORD_W);

   logic [WORD_W-1:0] sin;
   logic [WORD_W-1:0] sout;
   logic              take;

   assign take = bit_stb && (bit_cnt != FULL);

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_cnt   <= '0;
         sin       <= '0;
         word_done <= 1'b0;
         half_done <= 1'b0;
         rx_word   <= '0;
      end else begin
         word_done <= 1'b0;
         half_done <= 1'b0;
         if (!fs_q) begin
            bit_cnt <= '0;
         end else if (take) begin
            bit_cnt <= bit_cnt + 1'b1;
            sin     <= {sin[WORD_W-2:0], din_q};
            if (bit_cnt == MID_BIT) half_done <= 1'b1;
            if (bit_cnt == LAST_BIT) begin
               word_done <= 1'b1;
               rx_word   <= {sin[WORD_W-2:0], din_q};
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sout <= '0;
      end else if (fs_rise) begin
         sout <= tx_word;
      end else if (hi_load) begin
         sout[WORD_W-1 -: BYTE_W] <= hi_val;
      end else if (take) begin
         sout <= {sout[WORD_W-2:0], 1'b0};
      end
   end

   assign tx_bit     = sout[WORD_W-1];
   assign upper_byte = sin[BYTE_W-1:0];

endmodule

// File: rtl/codec_sp_regs.sv
module codec_sp_regs
   import codec_sp_pkg::*;
#(
   parameter int                       NUM_REGS     = 6,
   parameter logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS = '0
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         we,
   input  logic [ADDR_W-1:0]            waddr,
   input  logic [BYTE_W-1:0]            wdata,
   input  logic [ADDR_W-1:0]            raddr,
   output logic [BYTE_W-1:0]            rdata,
   output logic [NUM_REGS*BYTE_W-1:0]   flat
);
   logic [BYTE_W-1:0] bank [NUM_REGS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < NUM_REGS; k++) bank[k] <= REG_DEFAULTS[k*BYTE_W +: BYTE_W];
      end else if (we) begin
         for (int k = 0; k < NUM_REGS; k++) begin
            if (waddr == ADDR_W'(k + 1)) bank[k] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (raddr == ADDR_W'(k + 1)) rdata = bank[k];
      end
   end

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
         assign flat[g*BYTE_W +: BYTE_W] = bank[g];
      end
   endgenerate

endmodule

// File: rtl/codec_sp_ctrl.sv
module codec_sp_ctrl
   import codec_sp_pkg::*;
#(
   parameter int                         NUM_REGS     = 6,
   parameter int                         SYNC_STAGES  = 2,
   parameter bit                         SW_REQ_FLAG  = 1'b1,
   parameter logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS = 48'h0C_00_3F_A5_00_81
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         sclk,
   input  logic                         fs,
   input  logic                         din,
   input  logic                         hw_req,
   output logic                         dout,
   input  logic [WORD_W-1:0]            adc_word,
   output logic [WORD_W-1:0]            dac_word,
   output logic                         dac_valid,
   output logic [NUM_REGS*BYTE_W-1:0]   ctrl_regs
);
   localparam logic [CNT_W-1:0] ECHO_BITS = CNT_W'(BYTE_W);

   generate
      if (NUM_REGS < 1 || NUM_REGS > (2**ADDR_W) - 1) begin : g_bad_regs
         $error("codec_sp_ctrl: NUM_REGS out of address range");
      end
   endgenerate

   logic              sclk_fall, fs_q, fs_rise, din_q, hw_q;
   logic              bit_stb;
   logic              tx_bit, half_done, word_done;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] upper_byte;
   logic [WORD_W-1:0] rx_word, tx_word;
   logic              hi_load;
   logic [BYTE_W-1:0] hi_val;
   frame_e            frame_q;
   logic              in_sec;
   logic              hw_seen;
   logic              sw_req;
   logic [WORD_W-1:0] dac_next;
   cmd_t              rd_cmd, wr_cmd;
   logic              reg_we;
   logic [BYTE_W-1:0] rd_data;

   codec_sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .sclk(sclk), .fs(fs), .din(din), .hw_req(hw_req),
      .sclk_fall(sclk_fall), .fs_q(fs_q), .fs_rise(fs_rise), .din_q(din_q), .hw_q(hw_q)
   );

   assign bit_stb = sclk_fall & fs_q;
   assign in_sec  = (frame_q == FR_SEC);
   assign tx_word = in_sec ? '0 : adc_word;

   codec_sp_shift u_shift (
      .clk(clk), .rst(rst), .fs_q(fs_q), .fs_rise(fs_rise), .bit_stb(bit_stb),
      .din_q(din_q), .tx_word(tx_word), .hi_load(hi_load), .hi_val(hi_val),
      .tx_bit(tx_bit), .bit_cnt(bit_cnt), .half_done(half_done),
      .upper_byte(upper_byte), .word_done(word_done), .rx_word(rx_word)
   );

   // readback: command byte is known once half the secondary word is in
   assign rd_cmd  = cmd_t'(upper_byte);
   assign hi_load = half_done & in_sec;
   assign hi_val  = (rd_cmd.rd && cmd_hits(rd_cmd, NUM_REGS)) ? rd_data : '0;

   // write: decoded at the end of the secondary word
   assign wr_cmd = cmd_t'(rx_word[WORD_W-1 -: BYTE_W]);
   assign reg_we = word_done && in_sec && !wr_cmd.rd && cmd_hits(wr_cmd, NUM_REGS);

   codec_sp_regs #(.NUM_REGS(NUM_REGS), .REG_DEFAULTS(REG_DEFAULTS)) u_regs (
      .clk(clk), .rst(rst), .we(reg_we), .waddr(wr_cmd.addr),
      .wdata(rx_word[BYTE_W-1:0]), .raddr(rd_cmd.addr), .rdata(rd_data),
      .flat(ctrl_regs)
   );

   generate
      if (SW_REQ_FLAG) begin : g_flag_bit
         assign sw_req   = rx_word[0];
         assign dac_next = {rx_word[WORD_W-1:1], 1'b0};
      end else begin : g_full_word
         assign sw_req   = 1'b0;
         assign dac_next = rx_word;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         hw_seen <= 1'b0;
      end else if (fs_rise) begin
         hw_seen <= 1'b0;
      end else if (bit_stb && hw_q) begin
         hw_seen <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_q   <= FR_PRI;
         dac_word  <= '0;
         dac_valid <= 1'b0;
      end else begin
         dac_valid <= 1'b0;
         if (word_done) begin
            if (in_sec) begin
               frame_q <= FR_PRI;
            end else begin
               dac_word  <= dac_next;
               dac_valid <= 1'b1;
               frame_q   <= (sw_req || hw_seen) ? FR_SEC : FR_PRI;
            end
         end
      end
   end

   // command byte is echoed straight from the input line
   assign dout = (in_sec && fs_q && bit_cnt < ECHO_BITS) ? din : tx_bit;

endmodule

// File: rtl/codec_sp_ctrl_chk.sv
module codec_sp_ctrl_chk
   import codec_sp_pkg::*;
#(
   parameter int                         NUM_REGS     = 6,
   parameter logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS = '0
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       dac_valid,
   input logic [WORD_W-1:0]          dac_word,
   input logic [NUM_REGS*BYTE_W-1:0] ctrl_regs,
   input logic                       in_sec,
   input logic                       reg_we
);

   a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ctrl_regs == REG_DEFAULTS) && !dac_valid && !in_sec);

   a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
      dac_valid |=> !dac_valid);

   a_r3_word_moves_with_strobe: assert property (@(posedge clk) disable iff (rst)
      !$stable(dac_word) |-> dac_valid);

   a_r3_no_strobe_from_sec: assert property (@(posedge clk) disable iff (rst)
      dac_valid |-> !$past(in_sec));

   a_r7_regs_move_on_write: assert property (@(posedge clk) disable iff (rst)
      !$stable(ctrl_regs) |-> $past(reg_we));

   a_r7_write_only_in_sec: assert property (@(posedge clk) disable iff (rst)
      reg_we |-> in_sec);

endmodule

bind codec_sp_ctrl codec_sp_ctrl_chk #(
   .NUM_REGS(NUM_REGS), .REG_DEFAULTS(REG_DEFAULTS)
) u_chk (
   .clk(clk), .rst(rst), .dac_valid(dac_valid), .dac_word(dac_word),
   .ctrl_regs(ctrl_regs), .in_sec(in_sec), .reg_we(reg_we)
);

// File: tb/sim_codec_sp_ctrl.sv
module sim_codec_sp_ctrl;
   localparam int NREG = 6;
   localparam int HALF = 8;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              sclk = 1'b1, fs = 1'b0, din = 1'b0, hw_req = 1'b0;
   logic              dout;
   logic [15:0]       adc_word = '0;
   logic [15:0]       dac_word;
   logic              dac_valid;
   logic [NREG*8-1:0] ctrl_regs;

   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;
   logic [15:0] dac_q [$];
   logic [7:0]  shadow [1:NREG];

   always #2.5 clk = ~clk;

   codec_sp_ctrl u0 (
      .clk(clk), .rst(rst), .sclk(sclk), .fs(fs), .din(din), .hw_req(hw_req),
      .dout(dout), .adc_word(adc_word), .dac_word(dac_word),
      .dac_valid(dac_valid), .ctrl_regs(ctrl_regs)
   );

   task automatic check(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // scoreboard monitor for the parallel playback output (R3, R11)
   always @(negedge clk) begin
      cycles++;
      if (!rst && dac_valid) begin
         if (dac_q.size() == 0) begin
            check(1'b0, "R11 unexpected strobe", dac_word, 16'h0);
         end else begin
            logic [15:0] e;
            e = dac_q.pop_front();
            check(dac_word == e, "R3 dac_word", dac_word, e);
         end
      end
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: got %0d expected %0d", cycles, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic frame(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
      rx = '0;
      for (int i = 15; i > 15 - nbits; i--) begin
         @(negedge clk);
         sclk = 1'b1; fs = 1'b1; din = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = dout;
         sclk = 1'b0;
         repeat (HALF) @(negedge clk);
      end
      sclk = 1'b1; fs = 1'b0; din = 1'b0;
      repeat (4 * HALF) @(negedge clk);
   endtask

   task automatic primary(input logic [15:0] tx, input logic [15:0] adc, input string req);
      logic [15:0] rx;
      adc_word = adc;
      dac_q.push_back({tx[15:1], 1'b0});
      frame(tx, 16, rx);
      check(rx == adc, req, rx, adc);
   endtask

   task automatic secondary(input logic [15:0] cmd, input logic [15:0] exp_rx, input string req);
      logic [15:0] rx;
      frame(cmd, 16, rx);
      check(rx == exp_rx, req, rx, exp_rx);
   endtask

   task automatic regs_match(input string req);
      for (int a = 1; a <= NREG; a++)
         check(ctrl_regs[(a-1)*8 +: 8] == shadow[a], req,
               {8'h0, ctrl_regs[(a-1)*8 +: 8]}, {8'h0, shadow[a]});
   endtask

   initial begin
      logic [15:0] junk;
      shadow[1] = 8'h81; shadow[2] = 8'h00; shadow[3] = 8'hA5;
      shadow[4] = 8'h3F; shadow[5] = 8'h00; shadow[6] = 8'h0C;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      // R1 reset state, R10 defaults
      check(dac_word == 16'h0, "R1 dac_word after reset", dac_word, 16'h0);
      check(dac_valid == 1'b0, "R1 strobe after reset", {15'h0, dac_valid}, 16'h0);
      regs_match("R10 defaults after reset");

      // R2, R3, R6: back-to-back primaries without request
      primary(16'hA5C2, 16'h3C5A, "R2 sample out");
      primary(16'h1234, 16'h8001, "R6 next frame still primary");

      // R4 software request, R7 write
      primary(16'h7FFF, 16'h0F0F, "R4 primary with flag");
      secondary(16'h035E, 16'h0300, "R8 echo on write");
      shadow[3] = 8'h5E;
      regs_match("R7 write reg3");
      check(dac_word == 16'h7FFE, "R3 dac_word held over secondary", dac_word, 16'h7FFE);
      // R6: frame after secondary is primary
      primary(16'h2222, 16'hC3C3, "R6 primary after secondary");

      // R8 read back, no write on read
      primary(16'h0001, 16'h5555, "R4 request for read");
      secondary(16'h23FF, 16'h235E, "R8 readback reg3");
      regs_match("R8 read leaves register");

      // R5 pin request
      hw_req = 1'b1;
      primary(16'h4444, 16'hAAAA, "R5 primary with pin");
      hw_req = 1'b0;
      secondary(16'h0177, 16'h0100, "R5 secondary by pin");
      shadow[1] = 8'h77;
      regs_match("R5 write reg1 after pin request");

      // R9 no-op, out of range, reserved bits
      primary(16'h0001, 16'h0000, "R9 request");
      secondary(16'h00FF, 16'h0000, "R9 no-op echo");
      regs_match("R9 no-op changes nothing");
      primary(16'h0001, 16'hFFFF, "R9 request");
      secondary(16'h07AA, 16'h0700, "R9 out-of-range write echo");
      regs_match("R9 out-of-range write ignored");
      primary(16'h0001, 16'h1111, "R9 request");
      secondary(16'h4199, 16'h4100, "R9 reserved write echo");
      regs_match("R9 reserved bits block write");
      primary(16'h0001, 16'h2468, "R9 request");
      secondary(16'h2900, 16'h2900, "R9 out-of-range read is zero");
      primary(16'h0001, 16'h1357, "R10 request");
      secondary(16'h2400, 16'h243F, "R10 untouched reg4 reads default");

      // R11 truncated frame discarded
      frame(16'hFFFF, 5, junk);
      primary(16'h0F0E, 16'h9876, "R11 full frame after abort");
      check(dac_word == 16'h0F0E, "R11 word after abort", dac_word, 16'h0F0E);
      regs_match("R10 final register image");

      check(dac_q.size() == 0, "R3 all strobes seen", 16'(dac_q.size()), 16'h0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule